// File: doc/BRIEF.md
# Serial Audio Bit-Clock Ratio Checker

This block watches the bit clock and the word-select line of an I2S-style serial audio input, both sampled by the local system clock. It counts bit-clock rising edges in each frame, measured from one rising edge of word select to the next. At every frame boundary it decides whether the count fits one of three allowed ratios. These are 32, 48 and 64 bit clocks per frame, each with a tolerance of plus or minus two edges.

A single out-of-window frame raises a fault. The fault drives a tristate request to the output stage, so corrupted audio never reaches the speaker. It also drives an override flag that makes the clock selection logic stop using the bit clock as master clock. The fault clears by itself after two consecutive in-window frames. If word select stops toggling, a saturating counter reports the stall without waiting for a frame boundary that may never come. The block comes out of reset in the fault state, so the outputs stay floating until valid frames have been seen.

Top module: `bck_ratio_checker`

## Requirements
- R1: Frames of exactly 32, 48 or 64 bit-clock rising edges are accepted as valid.
- R2: The tolerance is plus or minus 2 around each ratio. Counts of 30..34, 46..50 and 62..66 are valid. Counts such as 29, 35, 40 and 67 are invalid.
- R3: An invalid frame asserts `out_tristate_req` and `bck_override` (both 1 = fault). This happens no later than 4 system-clock cycles after the closing word-select rising edge reaches the input.
- R4: `mclk_use_bck` equals `cfg_mclk_from_bck` while there is no fault. It is 0 whenever a fault is present, whatever the configuration.
- R5: The fault clears only after 2 consecutive valid frames. An invalid frame between them restarts the run.
- R6: A frame spans one word-select rising edge to the next. The first rising edge after reset only starts measurement and produces no verdict.
- R7: The per-frame count saturates at 67 and does not wrap. The 67th bit-clock edge without a word-select rising edge raises the fault immediately, and a frame of 160 edges is judged invalid.
- R8: During and right after reset, `out_tristate_req` = 1, `bck_override` = 1 and `mclk_use_bck` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the audio clocks |
| rst_n | input | 1 | Active-low asynchronous reset |
| bck_i | input | 1 | Serial audio bit clock (asynchronous) |
| ws_i | input | 1 | Serial audio word select / frame clock (asynchronous) |
| cfg_mclk_from_bck | input | 1 | Configuration request to derive the master clock from the bit clock |
| out_tristate_req | output | 1 | 1 = put the output stage in tristate |
| bck_override | output | 1 | 1 = bit clock must not be used as master clock |
| mclk_use_bck | output | 1 | Effective selection: master clock derived from bit clock |

## Verification
The embedded properties guard invariants that hold on every cycle. The frame counter never rises past its saturation value, and every word-select edge restarts the count. A frame verdict is never both good and bad, and a bad verdict always leads to the fault on the next cycle. The fault only falls right after a good verdict, a lone good verdict cannot clear it, and the bit clock is never selected while a fault is present. Only the bench scenarios can show that the window edges sit where they should (30/34, 46/50, 62/66 accepted, 29/35/40/67 rejected). The same holds for the unscored first frame after reset, recovery after two good frames, and stall detection mid-frame.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

  // Registered verdict of one frame (or a stall seen mid-frame)
  typedef struct packed {
    logic good;
    logic bad;
  } frame_ev_t;

  function automatic logic in_window(input int unsigned cnt,
                                     input int unsigned centre,
                                     input int unsigned tol);
    return (cnt + tol >= centre) && (cnt <= centre + tol);
  endfunction

  function automatic logic ratio_ok(input int unsigned cnt,
                                    input int unsigned ra,
                                    input int unsigned rb,
                                    input int unsigned rc,
                                    input int unsigned tol);
    return in_window(cnt, ra, tol) || in_window(cnt, rb, tol) ||
           in_window(cnt, rc, tol);
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/bcr_sync_edge.sv
module bcr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;
  logic              level;

  assign level = sh_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= (sh_q << 1) | STAGES'(din);
      prev_q <= level;
    end
  end

  assign rise = level & ~prev_q;

endmodule

// File: rtl/bcr_frame_counter.sv
module bcr_frame_counter
  import bcr_pkg::*;
#(
  parameter int RATIO_A = 32,
  parameter int RATIO_B = 48,
  parameter int RATIO_C = 64,
  parameter int TOL     = 2,
  parameter int SAT     = 67,
  parameter int CNT_W   = 7
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bck_rise,
  input  logic      ws_rise,
  output frame_ev_t ev
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             cnt_ok;
  logic             at_limit;
  logic             hit_sat;

  assign cnt_ok   = ratio_ok(32'(cnt_q), RATIO_A, RATIO_B, RATIO_C, TOL);
  assign at_limit = (cnt_q == CNT_W'(SAT));
  assign hit_sat  = bck_rise && (cnt_q == CNT_W'(SAT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      ev      <= '0;
    end else begin
      ev <= '0;
      if (ws_rise) begin
        ev.good <= armed_q && cnt_ok;
        ev.bad  <= armed_q && !cnt_ok;
        armed_q <= 1'b1;
        cnt_q   <= bck_rise ? CNT_W'(1) : '0;
      end else if (bck_rise && !at_limit) begin
        cnt_q  <= cnt_q + 1'b1;
        ev.bad <= hit_sat;
      end
    end
  end

  assert_cnt_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(SAT));

  assert_restart_on_ws_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ws_rise |=> cnt_q <= CNT_W'(1));

  assert_verdict_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev.good && ev.bad));

endmodule

// File: rtl/bcr_fault_fsm.sv
module bcr_fault_fsm
  import bcr_pkg::*;
#(
  parameter int GOOD_TO_CLEAR = 2,
  parameter int RUN_W         = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  frame_ev_t ev,
  output logic      fault
);
  logic [RUN_W-1:0] run_q;
  logic             fault_q;
  logic             run_done;

  assign run_done = (run_q == RUN_W'(GOOD_TO_CLEAR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b1;
      run_q   <= '0;
    end else if (ev.bad) begin
      fault_q <= 1'b1;
      run_q   <= '0;
    end else if (ev.good && fault_q) begin
      if (run_done) begin
        fault_q <= 1'b0;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign fault = fault_q;

  assert_bad_sets_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev.bad |=> fault_q);

  assert_clear_needs_good_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_q) |-> $past(ev.good));

  assert_lone_good_keeps_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (GOOD_TO_CLEAR > 1 && fault_q && run_q == '0 && ev.good) |=> fault_q);

endmodule

// File: rtl/bck_ratio_checker.sv
module bck_ratio_checker
  import bcr_pkg::*;
#(
  parameter int RATIO_A       = 32,
  parameter int RATIO_B       = 48,
  parameter int RATIO_C       = 64,
  parameter int TOL           = 2,
  parameter int GOOD_TO_CLEAR = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bck_i,
  input  logic ws_i,
  input  logic cfg_mclk_from_bck,
  output logic out_tristate_req,
  output logic bck_override,
  output logic mclk_use_bck
);
  localparam int SAT   = int'(max3(RATIO_A, RATIO_B, RATIO_C)) + TOL + 1;
  localparam int CNT_W = $clog2(SAT + 1);
  localparam int RUN_W = (GOOD_TO_CLEAR > 1) ? $clog2(GOOD_TO_CLEAR) : 1;

  logic      bck_rise;
  logic      ws_rise;
  frame_ev_t frame_ev;
  logic      fault;

  bcr_sync_edge #(.STAGES(SYNC_STAGES)) u_bck_sync (
    .clk(clk), .rst_n(rst_n), .din(bck_i), .rise(bck_rise)
  );

  bcr_sync_edge #(.STAGES(SYNC_STAGES)) u_ws_sync (
    .clk(clk), .rst_n(rst_n), .din(ws_i), .rise(ws_rise)
  );

  bcr_frame_counter #(
    .RATIO_A(RATIO_A), .RATIO_B(RATIO_B), .RATIO_C(RATIO_C),
    .TOL(TOL), .SAT(SAT), .CNT_W(CNT_W)
  ) u_counter (
    .clk(clk), .rst_n(rst_n), .bck_rise(bck_rise), .ws_rise(ws_rise),
    .ev(frame_ev)
  );

  bcr_fault_fsm #(.GOOD_TO_CLEAR(GOOD_TO_CLEAR), .RUN_W(RUN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ev(frame_ev), .fault(fault)
  );

  assign out_tristate_req = fault;
  assign bck_override     = fault;
  assign mclk_use_bck     = cfg_mclk_from_bck & ~fault;

  assert_no_bck_master_in_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_tristate_req |-> !mclk_use_bck);

endmodule

// File: tb/tb_bck_ratio_checker.sv
module tb_bck_ratio_checker;
  logic clk = 1'b0;
  logic rst_n, bck, ws, cfg;
  logic tri_req, ovr, use_bck;

  always #10 clk = ~clk;

  bck_ratio_checker dut (
    .clk(clk), .rst_n(rst_n), .bck_i(bck), .ws_i(ws),
    .cfg_mclk_from_bck(cfg), .out_tristate_req(tri_req),
    .bck_override(ovr), .mclk_use_bck(use_bck)
  );

  typedef struct {
    bit    fault;
    bit    use_b;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  // reference model state
  int prev_n  = -1;
  int run     = 0;
  bit m_fault = 1;

  function automatic bit good_count(int n);
    return (n >= 30 && n <= 34) || (n >= 46 && n <= 50) || (n >= 62 && n <= 66);
  endfunction

  task automatic push(string tag);
    exp_t e;
    e.fault = m_fault;
    e.use_b = cfg && !m_fault;
    e.tag   = tag;
    q.push_back(e);
  endtask

  task automatic score_prev();
    if (prev_n >= 0) begin
      if (good_count(prev_n)) begin
        if (m_fault) begin
          run++;
          if (run >= 2) begin
            m_fault = 0;
            run = 0;
          end
        end
      end else begin
        m_fault = 1;
        run = 0;
      end
    end
  endtask

  // one frame of n bit-clock edges; checks the verdict on the previous frame
  task automatic frame(int n, string tag);
    @(negedge clk) ws = 1'b1;
    repeat (8) @(negedge clk);
    score_prev();
    push(tag);
    for (int i = 0; i < n; i++) begin
      bck = 1'b1;
      repeat (2) @(negedge clk);
      bck = 1'b0;
      if (i == n / 2) ws = 1'b0;
      repeat (2) @(negedge clk);
      if (i + 1 == 67) begin
        repeat (8) @(negedge clk);
        m_fault = 1;
        run = 0;
        push({tag, " R7 stall mid-frame"});
      end
    end
    ws = 1'b0;
    repeat (4) @(negedge clk);
    prev_n = n;
  endtask

  // scoreboard monitor
  initial begin
    exp_t e;
    forever begin
      wait (q.size() > 0);
      e = q.pop_front();
      checks++;
      if (tri_req !== e.fault || ovr !== e.fault || use_bck !== e.use_b) begin
        errors++;
        $display("FAIL %s: tristate=%b override=%b use_bck=%b expected %b/%b/%b",
                 e.tag, tri_req, ovr, use_bck, e.fault, e.fault, e.use_b);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bck = 1'b0; ws = 1'b0; cfg = 1'b1;
    repeat (4) @(negedge clk);
    push("R8 reset held");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    push("R8 after reset");

    frame(32, "R6 first edge arms only");
    frame(32, "R5 one good frame not enough");
    frame(48, "R1 R5 second good clears (32)");
    frame(64, "R1 ratio 48");
    frame(30, "R1 ratio 64");
    frame(34, "R2 low edge 30");
    frame(46, "R2 high edge 34");
    frame(50, "R2 low edge 46");
    frame(62, "R2 high edge 50");
    frame(66, "R2 low edge 62");
    frame(29, "R2 high edge 66");
    frame(32, "R2 R3 count 29 rejected");
    frame(35, "R5 one good after fault");
    frame(32, "R2 R3 count 35 rejected");
    frame(32, "R5 run restarted");
    frame(40, "R5 recovered");
    frame(48, "R3 count 40 rejected");
    frame(48, "R5 one good");
    frame(64, "R5 recovered again");

    @(negedge clk) cfg = 1'b0;
    @(negedge clk) push("R4 cfg off no fault");
    @(negedge clk) cfg = 1'b1;
    @(negedge clk) push("R4 cfg on no fault");

    frame(67, "R1 ratio 64 again");
    frame(32, "R7 count 67 rejected");
    frame(32, "R5 one good");
    frame(160, "R5 recovered before long frame");
    frame(32, "R7 160-edge frame rejected no wrap");
    frame(0, "R5 one good");
    frame(48, "R3 empty frame rejected");
    frame(48, "R5 one good");
    frame(48, "R5 recovered end");

    wait (q.size() == 0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule